// File: doc/BRIEF.md
# Multilane PRBS Skew-Sweep Tester

This block is a bit-error-rate test engine for a group of parallel serial lanes that share one clock. Every lane owns a 31-stage pseudo-random pattern source, and each source feeds a delay line that can be set in whole bit periods. The lanes leave the block on `tx_data`, pass through the unit being tested, and come back on `rx_data`. On the return path, one detector per lane seeds itself from the incoming bits and, once locked, counts compared bits and mismatched bits.

A sweep is started with a single-cycle `start` pulse. The sweep takes one lane and gives it a growing skew against its neighbours, beginning at zero and adding one bit period per step. Each step waits a few cycles for the path to settle, clears and reseeds the detectors, and then lets that lane run for a fixed number of locked bits. When the lane's error count rises above `err_limit`, the sweep backs off by one step and reports that delay as the skew tolerance. If no step fails before the end of the delay range, the last delay is reported and the edge flag stays low. After a sweep the swept lane is left at the reported delay, with freshly cleared counters.

Top module: `skew_sweep_tester`

## Requirements
- R1: After reset, `busy`, `done` and `edge_found` are 0, `cur_delay` and `tolerance` are 0, and every lane has zero added delay.
- R2: Each `tx_data` bit equals the XOR of the bits sent on the same lane 31 and 28 bit periods earlier. All lanes carry the same sequence in the same cycle when their delays are equal, because they are frequency locked.
- R3: The swept lane's `tx_data` bit equals the bit that an unswept lane sent exactly `cur_delay` bit periods earlier, for delays from 0 to MAX_DLY-1.
- R4: After its counters are cleared, a detector collects exactly 31 received bits before it asserts `locked`. It counts no bit and no error while unlocked.
- R5: While locked, the bit count rises by one per received bit and the error count rises by one per mismatch with the predicted sequence. A clean PRBS stream gives an error count of 0.
- R6: A locked detector that sees more than LOSS_LIM mismatches inside one 64-bit window drops `locked` and seeds again.
- R7: The error and bit counters stop at their all-ones value and never wrap. Only a sweep-step clear returns them to 0.
- R8: A sweep begins at delay 0 and raises `cur_delay` by exactly one per step.
- R9: The first step whose error count is greater than `err_limit` ends the sweep with `edge_found`=1 and `tolerance` equal to that step's delay minus one. A failure at delay 0 reports 0.
- R10: If every step up to MAX_DLY-1 passes, the sweep ends with `edge_found`=0 and `tolerance`=MAX_DLY-1.
- R11: At `done`, `cur_delay` equals `tolerance`, the swept lane stays at that delay, and its counters have just been cleared.
- R12: A `start` pulse or a `lane_sel` change while `busy` is high has no effect on the running sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common bit clock for all lanes |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that begins a sweep when idle |
| lane_sel | input | LSW | Lane to sweep, sampled at start (out-of-range picks lane 0) |
| err_limit | input | CNT_W | Error count that a step must exceed to fail |
| rx_data | input | LANES | Returned lane bits |
| tx_data | output | LANES | Delayed pattern bits per lane |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished, result valid until next start |
| edge_found | output | 1 | A failing step was found |
| tolerance | output | DLY_W | Reported skew tolerance in bit periods |
| cur_delay | output | DLY_W | Delay currently applied to the swept lane |
| locked | output | LANES | Per-lane detector lock |
| sel_err_cnt | output | CNT_W | Error count of the swept lane |
| sel_bit_cnt | output | CNT_W | Compared-bit count of the swept lane |

## Verification
Two events can fall in the same cycle: the counter clear that opens a new sweep step, and a detector's own loss of lock on a corrupted lane. When delay d exceeds the bench's tolerance, the bench inverts the swept lane, so the detector keeps losing lock. The step into or out of that region therefore makes the clear collide with a lock drop. The clear must win. This is judged at `done`, where the clear follows a failing step: `locked` must stay low for exactly 31 bits, the bit count must stay 0 until then, and the count must then rise from 1.

// File: rtl/sst_pkg.sv
// Package: shared constants, state encoding and the pattern feedback function
// for the skew-sweep tester. Assumes a 31-stage shift register with the newest
// bit in position 0.
package sst_pkg;

    localparam int PRBS_LEN = 31;
    localparam int TAP_FAR  = 31;
    localparam int TAP_NEAR = 28;
    localparam int WIN_BITS = 64;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_SETTLE,
        CS_DWELL,
        CS_FINAL
    } sweep_state_e;

    // Next pattern bit from the bits sent 31 and 28 periods before.
    function automatic logic prbs_fb(input logic [PRBS_LEN-1:0] hist);
        return hist[TAP_FAR-1] ^ hist[TAP_NEAR-1];
    endfunction

endpackage

// File: rtl/sst_prbs_gen.sv
// Pattern source: one 31-stage LFSR emitting one registered bit per clock.
// Assumes SEED is nonzero; all lanes share clk so they stay frequency locked.
module sst_prbs_gen
    import sst_pkg::*;
#(
    parameter logic [PRBS_LEN-1:0] SEED = 31'h0000_0001
) (
    input  logic clk,
    input  logic rst_n,
    output logic bit_o
);

    logic [PRBS_LEN-1:0] hist_q;
    logic                nxt;

    // Feedback bit for this period.
    always_comb nxt = prbs_fb(hist_q);

    // Advance the register and register the emitted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= SEED;
            bit_o  <= 1'b0;
        end else begin
            hist_q <= {hist_q[PRBS_LEN-2:0], nxt};
            bit_o  <= nxt;
        end
    end

endmodule

// File: rtl/sst_lane_delay.sv
// Whole-bit delay line: output is the input delayed by 1 + dly clocks.
// Assumes MAX_DLY >= 3 and dly < MAX_DLY; a changed dly takes effect at once.
module sst_lane_delay #(
    parameter int MAX_DLY = 128,
    parameter int DLY_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] dly,
    input  logic             din,
    output logic             dout
);

    localparam int TAPS = MAX_DLY - 1;

    logic [TAPS-1:0] taps_q;
    logic            pick;

    // Select the tap for the requested delay.
    always_comb pick = (dly == '0) ? din : taps_q[dly - 1'b1];

    // Shift history and register the selected tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps_q <= '0;
            dout   <= 1'b0;
        end else begin
            taps_q <= {taps_q[TAPS-2:0], din};
            dout   <= pick;
        end
    end

endmodule

// File: rtl/sst_err_detector.sv
// Per-lane error detector: seeds its own LFSR from 31 received bits, then
// predicts each bit and counts compared bits and mismatches with saturation.
// Loses lock when more than LOSS_LIM mismatches fall in one 64-bit window.
// Assumes clr is a one-cycle pulse; clr overrides every other update.
module sst_err_detector
    import sst_pkg::*;
#(
    parameter int CNT_W    = 48,
    parameter int LOSS_LIM = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rx,
    output logic             locked,
    output logic [CNT_W-1:0] err_cnt,
    output logic [CNT_W-1:0] bit_cnt
);

    localparam int SEED_W = $clog2(PRBS_LEN);
    localparam int WPOS_W = $clog2(WIN_BITS);
    localparam int WERR_W = WPOS_W + 1;

    logic [PRBS_LEN-1:0] ref_q;
    logic [SEED_W-1:0]   seed_cnt_q;
    logic [WPOS_W-1:0]   win_pos_q;
    logic [WERR_W-1:0]   win_err_q;
    logic [WERR_W-1:0]   win_sum;
    logic                pred;
    logic                miss;
    logic                lose;

    // Predicted bit, mismatch and loss-of-lock decision.
    always_comb begin
        pred    = prbs_fb(ref_q);
        miss    = locked & (rx ^ pred);
        win_sum = win_err_q + WERR_W'(miss);
        lose    = locked && (win_sum > WERR_W'(LOSS_LIM));
    end

    // Seeding, prediction and lock tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ref_q      <= '0;
            seed_cnt_q <= '0;
            locked     <= 1'b0;
            win_pos_q  <= '0;
            win_err_q  <= '0;
        end else if (!locked) begin
            ref_q <= {ref_q[PRBS_LEN-2:0], rx};
            if (seed_cnt_q == SEED_W'(PRBS_LEN - 1)) begin
                seed_cnt_q <= '0;
                locked     <= 1'b1;
            end else begin
                seed_cnt_q <= seed_cnt_q + 1'b1;
            end
            win_pos_q <= '0;
            win_err_q <= '0;
        end else begin
            ref_q     <= {ref_q[PRBS_LEN-2:0], pred};
            win_pos_q <= win_pos_q + 1'b1;
            if (lose) begin
                locked    <= 1'b0;
                win_pos_q <= '0;
                win_err_q <= '0;
            end else if (win_pos_q == WPOS_W'(WIN_BITS - 1)) begin
                win_err_q <= '0;
            end else begin
                win_err_q <= win_sum;
            end
        end
    end

    // Saturating bit and error counters, counting only locked bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            err_cnt <= '0;
            bit_cnt <= '0;
        end else if (locked) begin
            if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
            if (miss && (err_cnt != '1)) err_cnt <= err_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sst_sweep_ctrl.sv
// Sweep controller: steps one lane's delay upward from zero, clearing the
// detectors after a settle time each step, until the lane's error count
// exceeds the limit or the range ends; then backs off one step, clears once
// more and reports. Assumes DWELL < 2**CNT_W and SETTLE >= 1.
module sst_sweep_ctrl
    import sst_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int LSW     = 2,
    parameter int MAX_DLY = 128,
    parameter int DLY_W   = 7,
    parameter int CNT_W   = 48,
    parameter int DWELL   = 1024,
    parameter int SETTLE  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LSW-1:0]   lane_sel,
    input  logic [CNT_W-1:0] err_limit,
    input  logic [CNT_W-1:0] sel_err,
    input  logic [CNT_W-1:0] sel_bits,
    output logic             busy,
    output logic             done,
    output logic             edge_found,
    output logic [DLY_W-1:0] tolerance,
    output logic [DLY_W-1:0] cur_delay,
    output logic [LSW-1:0]   sel_q,
    output logic             clr
);

    localparam int SET_W = $clog2(SETTLE + 1);

    sweep_state_e      st_q;
    logic [SET_W-1:0]  wait_q;
    logic              step_fail;
    logic              step_pass;
    logic              at_top;
    logic [DLY_W-1:0]  back_off;

    // Step verdicts and backed-off delay.
    always_comb begin
        step_fail = (st_q == CS_DWELL) && (sel_err > err_limit);
        step_pass = (st_q == CS_DWELL) && !step_fail && (sel_bits >= CNT_W'(DWELL));
        at_top    = (cur_delay == DLY_W'(MAX_DLY - 1));
        back_off  = (cur_delay == '0) ? '0 : cur_delay - 1'b1;
        busy      = (st_q != CS_IDLE);
        clr       = ((st_q == CS_SETTLE) || (st_q == CS_FINAL)) && (wait_q == '0);
    end

    // Sweep sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= CS_IDLE;
            wait_q     <= '0;
            cur_delay  <= '0;
            sel_q      <= '0;
            tolerance  <= '0;
            edge_found <= 1'b0;
            done       <= 1'b0;
        end else begin
            case (st_q)
                CS_IDLE: begin
                    if (start) begin
                        sel_q      <= (32'(lane_sel) < LANES) ? lane_sel : '0;
                        cur_delay  <= '0;
                        tolerance  <= '0;
                        edge_found <= 1'b0;
                        done       <= 1'b0;
                        wait_q     <= SET_W'(SETTLE - 1);
                        st_q       <= CS_SETTLE;
                    end
                end
                CS_SETTLE: begin
                    if (wait_q == '0) st_q <= CS_DWELL;
                    else              wait_q <= wait_q - 1'b1;
                end
                CS_DWELL: begin
                    if (step_fail) begin
                        edge_found <= 1'b1;
                        tolerance  <= back_off;
                        cur_delay  <= back_off;
                        wait_q     <= SET_W'(SETTLE - 1);
                        st_q       <= CS_FINAL;
                    end else if (step_pass && at_top) begin
                        tolerance <= cur_delay;
                        wait_q    <= SET_W'(SETTLE - 1);
                        st_q      <= CS_FINAL;
                    end else if (step_pass) begin
                        cur_delay <= cur_delay + 1'b1;
                        wait_q    <= SET_W'(SETTLE - 1);
                        st_q      <= CS_SETTLE;
                    end
                end
                CS_FINAL: begin
                    if (wait_q == '0) begin
                        done <= 1'b1;
                        st_q <= CS_IDLE;
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                default: st_q <= CS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/skew_sweep_tester.sv
// Top: per-lane pattern source, whole-bit delay line and error detector,
// plus one sweep controller that skews the selected lane. Assumes all lanes
// share clk; LANES is normally 4 or 10; the unit under test sits between
// tx_data and rx_data.
module skew_sweep_tester
    import sst_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int MAX_DLY  = 128,
    parameter int CNT_W    = 48,
    parameter int DWELL    = 1024,
    parameter int SETTLE   = 8,
    parameter int LOSS_LIM = 8,
    parameter logic [PRBS_LEN-1:0] SEED = 31'h2A5F_1C3B,
    localparam int LSW   = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int DLY_W = $clog2(MAX_DLY)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LSW-1:0]   lane_sel,
    input  logic [CNT_W-1:0] err_limit,
    input  logic [LANES-1:0] rx_data,
    output logic [LANES-1:0] tx_data,
    output logic             busy,
    output logic             done,
    output logic             edge_found,
    output logic [DLY_W-1:0] tolerance,
    output logic [DLY_W-1:0] cur_delay,
    output logic [LANES-1:0] locked,
    output logic [CNT_W-1:0] sel_err_cnt,
    output logic [CNT_W-1:0] sel_bit_cnt
);

    logic [LANES-1:0]            pat;
    logic [LANES-1:0][CNT_W-1:0] err_a;
    logic [LANES-1:0][CNT_W-1:0] bit_a;
    logic [LSW-1:0]              sel_q;
    logic                        clr;
    logic                        sel_locked;

    // Counters and lock of the swept lane.
    always_comb begin
        sel_err_cnt = err_a[sel_q];
        sel_bit_cnt = bit_a[sel_q];
        sel_locked  = locked[sel_q];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DLY_W-1:0] lane_dly;

        // Only the swept lane receives added delay.
        always_comb lane_dly = (32'(sel_q) == l) ? cur_delay : '0;

        sst_prbs_gen #(.SEED(SEED)) u_gen (
            .clk   (clk),
            .rst_n (rst_n),
            .bit_o (pat[l])
        );

        sst_lane_delay #(.MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .dly   (lane_dly),
            .din   (pat[l]),
            .dout  (tx_data[l])
        );

        sst_err_detector #(.CNT_W(CNT_W), .LOSS_LIM(LOSS_LIM)) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .rx      (rx_data[l]),
            .locked  (locked[l]),
            .err_cnt (err_a[l]),
            .bit_cnt (bit_a[l])
        );
    end

    sst_sweep_ctrl #(
        .LANES   (LANES),
        .LSW     (LSW),
        .MAX_DLY (MAX_DLY),
        .DLY_W   (DLY_W),
        .CNT_W   (CNT_W),
        .DWELL   (DWELL),
        .SETTLE  (SETTLE)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .lane_sel   (lane_sel),
        .err_limit  (err_limit),
        .sel_err    (sel_err_cnt),
        .sel_bits   (sel_bit_cnt),
        .busy       (busy),
        .done       (done),
        .edge_found (edge_found),
        .tolerance  (tolerance),
        .cur_delay  (cur_delay),
        .sel_q      (sel_q),
        .clr        (clr)
    );

endmodule

// File: rtl/sst_checker.sv
// Checker: temporal properties of the sweep and the swept lane's counters,
// attached to the top by bind. Observes only; drives nothing.
module sst_checker #(
    parameter int MAX_DLY = 128,
    parameter int DLY_W   = 7,
    parameter int LSW     = 2,
    parameter int CNT_W   = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             edge_found,
    input logic [DLY_W-1:0] tolerance,
    input logic [DLY_W-1:0] cur_delay,
    input logic [LSW-1:0]   sel_q,
    input logic             clr,
    input logic             sel_locked,
    input logic [CNT_W-1:0] sel_err,
    input logic [CNT_W-1:0] sel_bits
);

    AST_DELAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (cur_delay > $past(cur_delay)))
        |-> (cur_delay == $past(cur_delay) + 1'b1)); // R8

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sel_q)); // R12

    AST_NOEDGE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !edge_found) |-> (tolerance == DLY_W'(MAX_DLY - 1))); // R10

    AST_DONE_HOLDS_TOL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && (cur_delay == tolerance))); // R11

    AST_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sel_locked) && !$past(clr) && $stable(sel_q)) |-> $stable(sel_bits)); // R4

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_bits < $past(sel_bits)) |-> ($past(clr) || !$stable(sel_q))); // R7

    AST_ERR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err <= sel_bits); // R5

endmodule

bind skew_sweep_tester sst_checker #(
    .MAX_DLY (MAX_DLY),
    .DLY_W   (DLY_W),
    .LSW     (LSW),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .edge_found (edge_found),
    .tolerance  (tolerance),
    .cur_delay  (cur_delay),
    .sel_q      (sel_q),
    .clr        (clr),
    .sel_locked (sel_locked),
    .sel_err    (sel_err_cnt),
    .sel_bits   (sel_bit_cnt)
);

// File: tb/tb_skew_sweep_tester.sv
// Bench: sweeps every tolerance value of a 16-step configuration, rotating
// the swept lane, with a behavioural unit under test that inverts the swept
// lane once its delay passes the chosen tolerance.
module tb_skew_sweep_tester;

    localparam int LANES   = 4;
    localparam int MAX_DLY = 16;
    localparam int CNT_W   = 8;
    localparam int DLY_W   = 4;
    localparam int LSW     = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LSW-1:0]   lane_sel = '0;
    logic [CNT_W-1:0] err_limit = 8'd2;
    logic [LANES-1:0] rx_data;
    logic [LANES-1:0] tx_data;
    logic             busy, done, edge_found;
    logic [DLY_W-1:0] tolerance, cur_delay;
    logic [LANES-1:0] locked;
    logic [CNT_W-1:0] sel_err_cnt, sel_bit_cnt;

    int fault_t = 100;
    int fault_lane = 0;
    int n_chk = 0;
    int n_fail = 0;
    int max_seen = 0;
    int prev_d = 0;
    int step_bad = 0;
    logic [LANES-1:0][31:0] hist;
    logic [LANES-1:0] fmask;

    always #2 clk = ~clk;

    // Behavioural unit under test: inverts the swept lane beyond tolerance.
    always_comb begin
        fmask = '0;
        if ((fault_t < 0) || (int'(cur_delay) > fault_t)) fmask[fault_lane] = 1'b1;
        rx_data = tx_data ^ fmask;
    end

    skew_sweep_tester #(
        .LANES(LANES), .MAX_DLY(MAX_DLY), .CNT_W(CNT_W),
        .DWELL(40), .SETTLE(4), .LOSS_LIM(4)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .lane_sel(lane_sel),
        .err_limit(err_limit), .rx_data(rx_data), .tx_data(tx_data),
        .busy(busy), .done(done), .edge_found(edge_found),
        .tolerance(tolerance), .cur_delay(cur_delay), .locked(locked),
        .sel_err_cnt(sel_err_cnt), .sel_bit_cnt(sel_bit_cnt)
    );

    // History of each lane: hist[l][k] is the bit sent k+1 periods ago.
    always @(posedge clk) begin
        for (int l = 0; l < LANES; l++) hist[l] <= {hist[l][30:0], tx_data[l]};
    end

    // Step monitor: delay must only grow by one and its peak is recorded.
    always @(negedge clk) begin
        if (busy && (int'(cur_delay) > prev_d) && (int'(cur_delay) != prev_d + 1)) step_bad++;
        if (busy && (int'(cur_delay) > max_seen)) max_seen = int'(cur_delay);
        prev_d = int'(cur_delay);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One sweep of lane sel against a unit tolerating t bits (t<0: none).
    task automatic run_sweep(input int sel, input int t, input bit poke);
        int exp_tol, exp_peak, ref_l, d;
        bit exp_edge;
        exp_edge = (t < MAX_DLY - 1);
        exp_tol  = (t < 0) ? 0 : (exp_edge ? t : MAX_DLY - 1);
        exp_peak = (t < 0) ? 0 : (exp_edge ? t + 1 : MAX_DLY - 1);
        ref_l    = (sel + 1) % LANES;
        fault_t = t;
        fault_lane = sel;
        lane_sel = LSW'(sel);
        max_seen = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            cycles(100);
            d = int'(cur_delay);
            lane_sel = LSW'((sel + 2) % LANES);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy && (int'(cur_delay) >= d), "R12 start while busy", int'(cur_delay), d);
        end
        while (!done) @(negedge clk);
        chk(edge_found == exp_edge, "R9/R10 edge flag", edge_found, exp_edge);
        chk(int'(tolerance) == exp_tol, "R9/R10 tolerance", tolerance, exp_tol);
        chk(max_seen == exp_peak, "R8 peak step delay", max_seen, exp_peak);
        chk(int'(cur_delay) == exp_tol, "R11 delay kept at tolerance", cur_delay, exp_tol);
        if (t >= 0) begin
            chk(!locked[sel] && sel_bit_cnt == 0, "R4 cleared at done", sel_bit_cnt, 0);
            cycles(30);
            chk(!locked[sel], "R4 unlocked before 31 bits", locked[sel], 0);
            cycles(1);
            chk(locked[sel] && sel_bit_cnt == 0, "R4 locked at 31 bits", locked[sel], 1);
            cycles(1);
            chk(sel_bit_cnt == 1, "R5 first counted bit", sel_bit_cnt, 1);
            cycles(20);
            chk(sel_bit_cnt == 21, "R5 bit count rate", sel_bit_cnt, 21);
            chk(sel_err_cnt == 0, "R5 clean stream no errors", sel_err_cnt, 0);
            for (int k = 0; k < 6; k++) begin
                chk(tx_data[ref_l] == (hist[ref_l][30] ^ hist[ref_l][27]),
                    "R2 pattern recurrence", tx_data[ref_l], hist[ref_l][30] ^ hist[ref_l][27]);
                chk(tx_data[sel] == ((exp_tol == 0) ? tx_data[ref_l] : hist[ref_l][exp_tol-1]),
                    "R3 lane skew equals delay", tx_data[sel], exp_tol);
                chk(tx_data[ref_l] == tx_data[(sel + 2) % LANES], "R2 lanes frequency locked",
                    tx_data[ref_l], tx_data[(sel + 2) % LANES]);
                cycles(1);
            end
        end
    endtask

    initial begin
        cycles(4);
        chk(!busy && !done && !edge_found, "R1 reset flags", {busy, done, edge_found}, 0);
        chk(cur_delay == 0 && tolerance == 0, "R1 reset delay", cur_delay, 0);
        rst_n = 1'b1;
        cycles(40);
        chk(tx_data[0] == tx_data[1] && tx_data[2] == tx_data[3], "R1 lanes unskewed", tx_data, 0);

        for (int t = -1; t < MAX_DLY; t++) run_sweep((t + 1) % LANES, t, t == 7);
        chk(step_bad == 0, "R8 single-step increments", step_bad, 0);

        // Clean lane left running: bit counter must stop at all ones.
        cycles(300);
        chk(sel_bit_cnt == 8'hFF, "R7 bit count saturates", sel_bit_cnt, 255);
        cycles(5);
        chk(sel_bit_cnt == 8'hFF, "R7 bit count held", sel_bit_cnt, 255);

        // Always-corrupt lane: lock must drop, errors must saturate.
        run_sweep(2, -1, 1'b0);
        begin
            bit fell;
            bit was;
            fell = 1'b0;
            was = locked[2];
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if (was && !locked[2]) fell = 1'b1;
                was = locked[2];
            end
            chk(fell, "R6 lock dropped on errors", fell, 1);
        end
        cycles(3000);
        chk(sel_err_cnt == 8'hFF, "R7 error count saturates", sel_err_cnt, 255);
        cycles(40);
        chk(sel_err_cnt == 8'hFF, "R7 error count held", sel_err_cnt, 255);
        report();
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (180000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R8 actual %0d expected %0d", 0, 1);
        report();
    end

endmodule